// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock timing for an SPI shift engine from the module clock. A 13-bit control word offers two division laws, and one bit picks between them. The linear law divides by 2×(N2+1), with N2 an 8-bit field. The exponent law divides by 2^N1, with N1 a 4-bit field. An exponent of zero is treated as divide by two, so the serial clock never runs faster than half the module clock.

The divider issues a one-cycle strobe at every half-period. It also keeps its own copy of the serial clock level, which idles low. Each strobe is marked as a leading edge (the clock rises) or a trailing edge (the clock falls), so the shift engine knows when to launch and when to capture. The control word is captured on a start pulse and the counter is reloaded at the same time. The first strobe therefore lands exactly one half-period after the start, and writes to the control word during a burst have no effect until the next start. A stop pulse returns the divider to idle.

Top module: `sdiv_clkgen`

## Requirements
- R1: After reset, tick_o, lead_o, trail_o and sclk_o are all low.
- R2: When cfg_i bit 12 is 1 (linear mode), the half-period is N2+1 module clocks, with N2 = cfg_i[7:0] (0 to 255).
- R3: When cfg_i bit 12 is 0 (exponent mode) and N1 = cfg_i[11:8] is 1 to 15, the half-period is 2^(N1-1) module clocks.
- R4: In exponent mode, N1 = 0 gives a half-period of one module clock, which is divide by two.
- R5: Bit 12 alone selects the law. The field of the law that is not selected has no effect on the strobe spacing.
- R6: When start_i is sampled high at a clock edge, the first tick_o is high in the cycle that ends H edges later, where H is the half-period. Later ticks follow every H cycles.
- R7: The control word is captured only at start. Changes to cfg_i while a burst runs do not alter the spacing until the next start.
- R8: A start while running restarts cleanly. tick_o is held low in the cycle where start_i is high, sclk_o is low after that edge, and the next tick follows after a full H.
- R9: After stop_i, tick_o stays low and sclk_o is low until the next start.
- R10: sclk_o toggles at each tick. lead_o is tick_o while sclk_o is low, and trail_o is tick_o while sclk_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 13 | Control word: [7:0] linear N2, [11:8] exponent N1, [12] 1 = linear law |
| start_i | input | 1 | Start pulse: captures cfg_i and reloads the counter |
| stop_i | input | 1 | Stop pulse: return to idle |
| tick_o | output | 1 | Half-period strobe |
| sclk_o | output | 1 | Serial clock level, idles low |
| lead_o | output | 1 | Strobe that raises sclk_o |
| trail_o | output | 1 | Strobe that lowers sclk_o |

## Verification
The critical collision is a start pulse arriving in the same cycle as the terminal count. The bench provokes it by raising start_i exactly in the cycle where tick_o is observed high. It then checks three things: tick_o and both edge outputs drop in that cycle, sclk_o is low after the edge, and the next strobe arrives after a full half-period. A second collision is a change to the control word while a burst is running. The bench judges it by the strobe spacing, which must stay the same until a new start.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;

  localparam int unsigned DEF_LIN_W = 8;
  localparam int unsigned DEF_EXP_W = 4;
endpackage

// File: rtl/sdiv_cfg_latch.sv
module sdiv_cfg_latch
  import sdiv_pkg::*;
#(
  parameter int unsigned LIN_W = DEF_LIN_W,
  parameter int unsigned EXP_W = DEF_EXP_W,
  parameter int unsigned CNT_W = 14,
  localparam int unsigned MODE_BIT = LIN_W + EXP_W,
  localparam int unsigned CFG_W = MODE_BIT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] load_val_o,
  output logic [CNT_W-1:0] reload_o
);
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;
  div_mode_e        mode;
  logic [CNT_W:0]   pow_v;
  logic [CNT_W:0]   pow_m1;
  logic [CNT_W-1:0] reload_q;

  assign lin_n = cfg_i[LIN_W-1:0];
  assign exp_n = cfg_i[MODE_BIT-1:LIN_W];
  assign mode  = div_mode_e'(cfg_i[MODE_BIT]);

  // half-period - 1 for exponent law: 2^(N1-1) - 1, N1 = 0 clamps to 0
  always_comb begin
    pow_v  = '0;
    pow_m1 = '0;
    if (exp_n != '0) begin
      pow_v  = (CNT_W+1)'(1) << (exp_n - 1'b1);
      pow_m1 = pow_v - 1'b1;
    end
  end

  always_comb begin
    if (mode == DIV_LIN) load_val_o = CNT_W'(lin_n);
    else                 load_val_o = pow_m1[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reload_q <= '0;
    else if (start_i) reload_q <= load_val_o;
  end

  assign reload_o = reload_q;

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(reload_q));
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  // start and stop own the edge: no strobe escapes with them
  assign tick_o = active_q && (cnt_q == '0) && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= load_val_i;
    end else if (stop_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !tick_o);
  assert_restart_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/sdiv_phase.sv
module sdiv_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sclk_q <= 1'b0;
    else if (start_i || stop_i) sclk_q <= 1'b0;
    else if (tick_i)            sclk_q <= ~sclk_q;
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = tick_i && !sclk_q;
  assign trail_o = tick_i && sclk_q;

  assert_restart_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !sclk_q);
  assert_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (sclk_q != $past(sclk_q)));
  assert_edge_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_o, trail_o}));
endmodule

// File: rtl/sdiv_clkgen.sv
module sdiv_clkgen
  import sdiv_pkg::*;
#(
  parameter int unsigned LIN_W = DEF_LIN_W,
  parameter int unsigned EXP_W = DEF_EXP_W,
  localparam int unsigned CFG_W = LIN_W + EXP_W + 1,
  localparam int unsigned EXP_SPAN = (1 << EXP_W) - 2,
  localparam int unsigned CNT_W = (LIN_W > EXP_SPAN) ? LIN_W : EXP_SPAN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             tick_o,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload;
  logic             tick;

  sdiv_cfg_latch #(
    .LIN_W(LIN_W),
    .EXP_W(EXP_W),
    .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cfg_i     (cfg_i),
    .load_val_o(load_val),
    .reload_o  (reload)
  );

  sdiv_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .load_val_i(load_val),
    .reload_i  (reload),
    .tick_o    (tick)
  );

  sdiv_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .tick_i (tick),
    .sclk_o (sclk_o),
    .lead_o (lead_o),
    .trail_o(trail_o)
  );

  assign tick_o = tick;

  assert_edge_cover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o == (lead_o || trail_o));
endmodule

// File: tb/sdiv_clkgen_test.sv
module sdiv_clkgen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] cfg_i = '0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        tick_o, sclk_o, lead_o, trail_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sdiv_clkgen uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .start_i(start_i),
    .stop_i (stop_i),
    .tick_o (tick_o),
    .sclk_o (sclk_o),
    .lead_o (lead_o),
    .trail_o(trail_o)
  );

  function automatic logic [12:0] mk_cfg(bit lin, int n1, int n2);
    return {lin, 4'(n1), 8'(n2)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(logic [12:0] cfg);
    @(negedge clk_i);
    cfg_i   = cfg;
    start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk_i);
    stop_i = 1'b1;
    @(posedge clk_i);
    #1 stop_i = 1'b0;
  endtask

  task automatic to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      #1;
      n++;
    end while (!tick_o && n < 2000);
  endtask

  task automatic spacing(logic [12:0] cfg, int h, string req);
    int n;
    kick(cfg);
    to_tick(n);
    chk(n == h, {req, " first strobe"}, n, h);
    to_tick(n);
    chk(n == h, {req, " second strobe"}, n, h);
    halt();
  endtask

  task automatic t_reset();
    #1;
    chk(!tick_o && !sclk_o && !lead_o && !trail_o, "R1 reset outputs",
        {tick_o, sclk_o, lead_o, trail_o}, 0);
  endtask

  task automatic t_linear();
    spacing(mk_cfg(1, 0, 0), 1, "R2 N2=0");
    spacing(mk_cfg(1, 0, 3), 4, "R2 N2=3");
    spacing(mk_cfg(1, 0, 255), 256, "R2 N2=255");
  endtask

  task automatic t_exp();
    spacing(mk_cfg(0, 0, 0), 1, "R4 N1=0");
    spacing(mk_cfg(0, 1, 0), 1, "R3 N1=1");
    spacing(mk_cfg(0, 3, 0), 4, "R3 N1=3");
    spacing(mk_cfg(0, 5, 0), 16, "R3 N1=5");
  endtask

  task automatic t_select();
    spacing(mk_cfg(1, 4, 2), 3, "R5 lin with exp field set");
    spacing(mk_cfg(0, 4, 2), 8, "R5 exp with lin field set");
  endtask

  task automatic t_edges();
    int n;
    kick(mk_cfg(1, 0, 2));
    to_tick(n);
    chk(n == 3, "R6 first strobe delay", n, 3);
    chk(lead_o && !trail_o, "R10 first strobe leads", {lead_o, trail_o}, 2);
    @(negedge clk_i); #1;
    chk(sclk_o == 1'b1, "R10 sclk high after lead", sclk_o, 1);
    to_tick(n);
    chk(trail_o && !lead_o, "R10 second strobe trails", {lead_o, trail_o}, 1);
    @(negedge clk_i); #1;
    chk(sclk_o == 1'b0, "R10 sclk low after trail", sclk_o, 0);
    halt();
  endtask

  task automatic t_hold();
    int n;
    kick(mk_cfg(1, 0, 3));
    @(negedge clk_i);
    cfg_i = mk_cfg(1, 0, 9);
    to_tick(n);
    chk(n == 3, "R7 first strobe after mid-burst write", n, 3);
    to_tick(n);
    chk(n == 4, "R7 spacing kept", n, 4);
    to_tick(n);
    chk(n == 4, "R7 spacing kept again", n, 4);
    halt();
    spacing(mk_cfg(1, 0, 9), 10, "R7 new value at next start");
  endtask

  task automatic t_restart();
    int n;
    kick(mk_cfg(1, 0, 3));
    to_tick(n);
    start_i = 1'b1;
    #1;
    chk(!tick_o && !lead_o && !trail_o, "R8 strobe masked by start",
        {tick_o, lead_o, trail_o}, 0);
    @(posedge clk_i);
    #1 start_i = 1'b0;
    chk(sclk_o == 1'b0, "R8 sclk low after restart", sclk_o, 0);
    to_tick(n);
    chk(n == 4, "R8 full half-period after restart", n, 4);
    @(negedge clk_i); #1;
    @(negedge clk_i);
    chk(sclk_o == 1'b1, "R8 sclk high mid-phase", sclk_o, 1);
    start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    chk(sclk_o == 1'b0, "R8 mid-phase restart drops sclk", sclk_o, 0);
    to_tick(n);
    chk(n == 4, "R8 mid-phase restart spacing", n, 4);
    halt();
  endtask

  task automatic t_stop();
    int seen = 0;
    kick(mk_cfg(1, 0, 0));
    @(negedge clk_i); @(negedge clk_i);
    halt();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); #1;
      if (tick_o || sclk_o) seen++;
    end
    chk(seen == 0, "R9 quiet after stop", seen, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    #22 rst_ni = 1'b1;
    t_linear();
    t_exp();
    t_select();
    t_edges();
    t_hold();
    t_restart();
    t_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule